// File: doc/BRIEF.md
# Interrupt Request Capture and Mask Stage

This block sits in front of an interrupt priority resolver. It takes a set of asynchronous request lines, brings each one into the clock domain through a two-flop synchroniser, and records it in a request register. Each line can be recognised on a rising edge or on a high level. The mode is set by a single input that software may change at run time. A mask register then removes selected lines before the resolver sees them. The raw request register and the mask register both stay visible on separate outputs, so status reads do not depend on one another.

When the processor's first acknowledge pulse arrives, the block receives the granted level. It clears that level's request bit, and for that cycle it admits no new requests. A request that was ready during that cycle is not lost. It is recorded one cycle later. Writing the first initialisation word clears the mask and disarms every line's edge history. Priority resolution, in-service tracking and vector output are handled by neighbouring blocks.

Top module: `irq_capture`

## Requirements
- R1: While rst_ni is low, and after its release until other inputs act, req_raw_o, req_masked_o and mask_o are all zero.
- R2: A change on irq_i reaches the synchroniser output after two rising edges and req_raw_o after the third. A line raised just after edge 0 shows in req_raw_o only after edge 3.
- R3: In edge mode (level_mode_i = 0), a line that was last seen low and is then seen high sets its request bit. After that bit is cleared by acknowledge, the line held high creates no further request.
- R4: In edge mode, a line must be seen low by the synchroniser before a new rise sets its bit again.
- R5: In edge mode, a set request bit stays set until acknowledged, even if the line drops. No bit falls without an acknowledge.
- R6: In level mode (level_mode_i = 1), each request bit follows the synchronised line one edge later. A line that drops before acknowledge clears its bit.
- R7: In level mode, a line still high after its bit was cleared by acknowledge sets the bit again on the following edge.
- R8: On an edge where ack_i is high, the bit numbered ack_level_i (bit n = line n) is cleared. No bit that was clear becomes set on that edge. A request that was ready then is recorded on the next edge.
- R9: req_masked_o bit n is zero when mask_o bit n is 1, and it equals req_raw_o bit n when mask_o bit n is 0. Other lines are unaffected.
- R10: req_raw_o does not depend on the mask. Masked lines still show their requests there.
- R11: A mask write (mask_we_i) loads mask_data_i into mask_o at the next edge.
- R12: init_i clears mask_o at the next edge, with priority over a mask write in the same cycle. It disarms every line and admits no new request on that edge, so a line high throughout must go low and high again to request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | Asynchronous request lines |
| level_mode_i | input | 1 | 1 = level recognition, 0 = rising-edge recognition |
| init_i | input | 1 | First initialisation word written: clear mask and edge history |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_data_i | input | NUM_LINES | Mask write data, 1 blocks a line |
| ack_i | input | 1 | First acknowledge pulse |
| ack_level_i | input | LVL_W | Level granted by the acknowledge |
| req_raw_o | output | NUM_LINES | Request register, unmasked |
| req_masked_o | output | NUM_LINES | Requests passed to priority logic |
| mask_o | output | NUM_LINES | Mask register readback |

## Verification
The assertions check on every cycle that acknowledge clears the granted bit and admits no new bit, and that edge-mode bits never fall without an acknowledge. They also check that the mask updates correctly after a write and after init, that masked lines never reach the priority output, and the reset state. Other behaviour needs a line's history over several cycles, and only the bench scenarios can show it. This covers the three-edge latency, the need for the line to go low before re-arming, level-mode re-requesting after acknowledge, recording a request that was held off by an acknowledge one edge late, and init suppressing a line that stays high.

// File: rtl/irq_capture_pkg.sv
package irq_capture_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_capture_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  trig_mode_e mode_i,
  input  logic       freeze_i,
  input  logic       clear_i,
  input  logic       init_i,
  output logic       req_o
);
  logic armed_q, req_q, hold;
  logic edge_set;

  assign hold     = freeze_i | init_i;
  assign edge_set = (mode_i == TRIG_EDGE) & armed_q & line_i & ~hold & ~clear_i;

  // armed_q: line has been seen low since the last edge-mode capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (init_i)   armed_q <= 1'b0;
    else if (!line_i)  armed_q <= 1'b1;
    else if (edge_set) armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    req_q <= 1'b0;
    else if (clear_i)               req_q <= 1'b0;
    else if (hold)                  req_q <= req_q;
    else if (mode_i == TRIG_LEVEL)  req_q <= line_i;
    else if (edge_set)              req_q <= 1'b1;
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (init_i) mask_q <= '0;
    else if (we_i)   mask_q <= data_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_capture_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LVL_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 level_mode_i,
  input  logic                 init_i,
  input  logic                 mask_we_i,
  input  logic [NUM_LINES-1:0] mask_data_i,
  input  logic                 ack_i,
  input  logic [LVL_W-1:0]     ack_level_i,
  output logic [NUM_LINES-1:0] req_raw_o,
  output logic [NUM_LINES-1:0] req_masked_o,
  output logic [NUM_LINES-1:0] mask_o
);
  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] req_vec;
  trig_mode_e           mode;

  assign mode    = trig_mode_e'(level_mode_i);
  assign clr_vec = ack_i ? (NUM_LINES'(1) << ack_level_i) : '0;

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_i),
    .q_o    (line_sync)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    irq_line_cell i_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_i   (line_sync[n]),
      .mode_i   (mode),
      .freeze_i (ack_i),
      .clear_i  (clr_vec[n]),
      .init_i   (init_i),
      .req_o    (req_vec[n])
    );
  end

  irq_mask_reg #(.WIDTH(NUM_LINES)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .we_i   (mask_we_i),
    .data_i (mask_data_i),
    .mask_o (mask_o)
  );

  assign req_raw_o    = req_vec;
  assign req_masked_o = req_vec & ~mask_o;
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned LVL_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 level_mode_i,
  input logic                 init_i,
  input logic                 mask_we_i,
  input logic [NUM_LINES-1:0] mask_data_i,
  input logic                 ack_i,
  input logic [LVL_W-1:0]     ack_level_i,
  input logic [NUM_LINES-1:0] req_raw_o,
  input logic [NUM_LINES-1:0] req_masked_o,
  input logic [NUM_LINES-1:0] mask_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (req_raw_o == '0 && mask_o == '0);
    end else begin
      assert_mask_blocks_R9: assert ((req_masked_o & mask_o) == '0);
    end
  end

  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (req_raw_o[$past(ack_level_i)] == 1'b0));

  assert_ack_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ((req_raw_o & ~$past(req_raw_o)) == '0));

  assert_edge_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_mode_i && !ack_i) |=> (($past(req_raw_o) & ~req_raw_o) == '0));

  assert_mask_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && !init_i) |=> (mask_o == $past(mask_data_i)));

  assert_init_mask_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (mask_o == '0));
endmodule

bind irq_capture irq_capture_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .level_mode_i (level_mode_i),
  .init_i       (init_i),
  .mask_we_i    (mask_we_i),
  .mask_data_i  (mask_data_i),
  .ack_i        (ack_i),
  .ack_level_i  (ack_level_i),
  .req_raw_o    (req_raw_o),
  .req_masked_o (req_masked_o),
  .mask_o       (mask_o)
);

// File: tb/test_irq_capture.sv
`timescale 1ns/1ps
module test_irq_capture;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] irq = '0;
  logic         level_mode = 1'b0;
  logic         init = 1'b0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_data = '0;
  logic         ack = 1'b0;
  logic [2:0]   ack_level = '0;
  logic [N-1:0] req_raw, req_masked, mask_q;

  irq_capture i_irq_capture (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .irq_i        (irq),
    .level_mode_i (level_mode),
    .init_i       (init),
    .mask_we_i    (mask_we),
    .mask_data_i  (mask_data),
    .ack_i        (ack),
    .ack_level_i  (ack_level),
    .req_raw_o    (req_raw),
    .req_masked_o (req_masked),
    .mask_o       (mask_q)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         due;
    int         view;   // 0 raw, 1 masked, 2 mask
    logic [N-1:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare pending items shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [N-1:0] act;
        it = q.pop_front();
        act = (it.view == 0) ? req_raw : (it.view == 1) ? req_masked : mask_q;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s view=%0d: got %h expected %h", it.req, it.view, act, it.exp);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input int view, input logic [N-1:0] val, input string req);
    item_t it;
    it.due = cyc; it.view = view; it.exp = val; it.req = req;
    q.push_back(it);
  endtask

  task automatic pulse_ack(input int lvl);
    ack = 1'b1; ack_level = 3'(lvl);
    step(1);
    ack = 1'b0;
  endtask

  initial begin
    step(2);
    expect_val(0, 8'h00, "R1");
    expect_val(2, 8'h00, "R1");
    rst_ni = 1'b1;
    step(2);
    expect_val(0, 8'h00, "R1");
    expect_val(1, 8'h00, "R1");

    // edge capture and latency
    irq[2] = 1'b1;
    step(2); expect_val(0, 8'h00, "R2");
    step(1); expect_val(0, 8'h04, "R2");
    expect_val(1, 8'h04, "R3");
    pulse_ack(2); expect_val(0, 8'h00, "R8");
    step(4); expect_val(0, 8'h00, "R3");

    // re-arm only after low
    irq[2] = 1'b0; step(3);
    irq[2] = 1'b1; step(3); expect_val(0, 8'h04, "R4");
    irq[2] = 1'b0; step(4); expect_val(0, 8'h04, "R5");
    pulse_ack(2); expect_val(0, 8'h00, "R8");

    // mask
    mask_we = 1'b1; mask_data = 8'h0A; step(1);
    mask_we = 1'b0; expect_val(2, 8'h0A, "R11");
    irq = 8'h0B; step(3);
    expect_val(0, 8'h0B, "R10");
    expect_val(1, 8'h01, "R9");

    // acknowledge freeze
    irq[5] = 1'b1; step(2);
    pulse_ack(0); expect_val(0, 8'h0A, "R8");
    step(1); expect_val(0, 8'h2A, "R8");
    expect_val(1, 8'h20, "R9");

    // level mode
    level_mode = 1'b1; irq = 8'h00; step(3);
    expect_val(0, 8'h00, "R6");
    irq[6] = 1'b1; step(3); expect_val(0, 8'h40, "R6");
    irq[6] = 1'b0; step(3); expect_val(0, 8'h00, "R6");
    irq[6] = 1'b1; step(3); expect_val(0, 8'h40, "R6");
    pulse_ack(6); expect_val(0, 8'h00, "R8");
    step(1); expect_val(0, 8'h40, "R7");
    expect_val(1, 8'h40, "R9");

    // init
    level_mode = 1'b0;
    pulse_ack(6); expect_val(0, 8'h00, "R8");
    init = 1'b1; mask_we = 1'b1; mask_data = 8'hFF; step(1);
    init = 1'b0; mask_we = 1'b0; expect_val(2, 8'h00, "R12");
    irq[4] = 1'b1; step(2);
    init = 1'b1; step(1); init = 1'b0;
    expect_val(0, 8'h00, "R12");
    step(3); expect_val(0, 8'h00, "R12");
    irq[4] = 1'b0; step(3);
    irq[4] = 1'b1; step(3); expect_val(0, 8'h10, "R12");

    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule